// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block walks a chain of receive descriptors held in host memory for a network receive path. When it is kicked, it takes the starting descriptor pointer and a pointer-width mode. It fetches the descriptor through a single-request DMA handshake and checks who owns the descriptor. A free descriptor is offered to a data mover as a fill target, given as a buffer address and a byte capacity. When the data mover reports the received length and its checksum findings, the engine rewrites the command/status and extended-status words. It stores only those two words back to memory and then follows the link word to the next descriptor.

Two descriptor layouts are supported. In the narrow layout the link, buffer, command/status and extended-status entries are all 32-bit words, so command/status sits at byte 8. In the wide layout the link and buffer entries are 64-bit, which moves command/status to byte 16 and extended status to byte 20. The layout is latched when the engine is kicked and is held for the whole chain. The engine gives single-cycle interrupt pulses for a completed packet, for a descriptor that asks to be reported, and for running out of descriptors.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset `busy`, `dma_req`, `fill_req`, `irq_ok`, `irq_desc` and `irq_idle` are all 0.
- R2: A kick while `enable` is 1 starts a full descriptor read (`dma_write`=0) at the pointer's low 30 bits. The read length is 16 bytes in 32-bit mode and 24 bytes in 64-bit mode. A kick while `enable` is 0 is ignored.
- R3: If the descriptor just read has command/status bit 31 (ownership) set, `irq_idle` pulses and the engine goes idle with no fill request.
- R4: Otherwise `fill_req` is raised with `fill_ptr` set to the buffer pointer and `fill_cap` set to command/status bits 15:0. In 32-bit mode only the low 32 bits of the buffer and link entries are used, and the upper bits are taken as zero.
- R5: On fill completion command/status gets bit 31 set, bit 30 (more) cleared and bit 27 (ok) set, with bits 15:0 replaced by `pkt_len`. All other bits are kept.
- R6: When `ext_en` is 1 and `chk_ip` is 1, extended status ORs in bit 17, and bit 18 if `chk_ip_err`. It then ORs in bit 19 (and bit 20 if `chk_tcp_err`) when `chk_tcp` is set, or else bit 21 (and bit 22 if `chk_udp_err`) when `chk_udp` is set. With `ext_en` 0, extended status is written back unchanged.
- R7: Write-back is a write of 8 bytes at pointer[29:0]+8 in 32-bit mode or +16 in 64-bit mode. `dma_wdata` is {extended status, command/status}.
- R8: The cycle after write-back is done, `irq_ok` pulses. `irq_desc` pulses with it if command/status bit 29 is set.
- R9: After write-back, a zero link pulses `irq_idle` one cycle after `irq_ok` and the engine goes idle. A nonzero link becomes the pointer and a full read at link[29:0] follows.
- R10: Only one DMA request is outstanding. `dma_req`, `dma_addr` and `dma_write` are held until `dma_done`, and `dma_req` and `fill_req` are never high together.
- R11: Clearing `enable` makes the engine go idle only after the current write-back completes, with no further read. A fill in progress still finishes and is written back.
- R12: The mode is sampled at the kick. Changing `mode64` during a chain does not change that chain's lengths or offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receive enable level |
| kick | input | 1 | Start pulse, honoured when idle |
| mode64 | input | 1 | 1 selects the 64-bit descriptor layout |
| ext_en | input | 1 | Extended-status update enable |
| ptr_in | input | 64 | Starting descriptor pointer |
| dma_req | output | 1 | DMA request, held until done |
| dma_write | output | 1 | 1 = write-back, 0 = descriptor read |
| dma_addr | output | 30 | DMA byte address |
| dma_len | output | 5 | DMA byte count |
| dma_wdata | output | 64 | Write-back data {extsts, cmdsts} |
| dma_done | input | 1 | DMA completion pulse |
| rd_link | input | 64 | Read descriptor link entry |
| rd_buf | input | 64 | Read descriptor buffer entry |
| rd_cmd | input | 32 | Read command/status word |
| rd_ext | input | 32 | Read extended-status word |
| fill_req | output | 1 | Fill target offered to the data mover |
| fill_ptr | output | 64 | Buffer address to fill |
| fill_cap | output | 16 | Buffer capacity in bytes |
| fill_done | input | 1 | Packet received pulse |
| pkt_len | input | 16 | Received packet length |
| chk_ip | input | 1 | Packet is IP |
| chk_ip_err | input | 1 | IP header checksum bad |
| chk_tcp | input | 1 | Packet is TCP |
| chk_tcp_err | input | 1 | TCP checksum bad |
| chk_udp | input | 1 | Packet is UDP |
| chk_udp_err | input | 1 | UDP checksum bad |
| busy | output | 1 | Engine not idle |
| irq_ok | output | 1 | Packet-ok interrupt pulse |
| irq_desc | output | 1 | Per-descriptor interrupt pulse |
| irq_idle | output | 1 | Receive-idle interrupt pulse |

## Verification
The assertions assume that `dma_done` arrives only while `dma_req` is high and that `fill_done` arrives only while `fill_req` is high. Each is assumed to last exactly one cycle, with the read-data entries valid in that cycle. The bench keeps to this by waiting on the falling edge for the matching request and then raising the done pulse for a single cycle. Chains use a mix of masked upper pointer bits, junk upper link bits in 32-bit mode, a layout switch in mid-chain and a disable during the fill, so that the stated ordering and ignore rules are all observed at the ports.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_FILL,
        S_WB,
        S_ADV
    } state_e;

    localparam int CMD_OWN   = 31;
    localparam int CMD_MORE  = 30;
    localparam int CMD_INTR  = 29;
    localparam int CMD_OK    = 27;
    localparam int LEN_W     = 16;

    localparam int EXT_IP    = 17;
    localparam int EXT_IPERR = 18;
    localparam int EXT_TCP   = 19;
    localparam int EXT_TCPE  = 20;
    localparam int EXT_UDP   = 21;
    localparam int EXT_UDPE  = 22;

    typedef struct packed {
        logic [63:0] link;
        logic [63:0] bufp;
        logic [31:0] cmd;
        logic [31:0] ext;
    } desc_t;

    typedef struct packed {
        logic ip;
        logic ip_err;
        logic tcp;
        logic tcp_err;
        logic udp;
        logic udp_err;
    } chk_t;
endpackage

// File: rtl/rxd_addr_gen.sv
module rxd_addr_gen #(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 5
) (
    input  logic [63:0]       ptr,
    input  logic              wide,
    input  logic              wb,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len
);
    localparam int WORD_B   = 4;
    localparam int NARROW_B = 4 * WORD_B;
    localparam int WIDE_B   = NARROW_B + 2 * WORD_B;
    localparam int CMD_N    = 2 * WORD_B;
    localparam int CMD_W    = 4 * WORD_B;
    localparam int STAT_B   = 2 * WORD_B;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;

    always_comb begin
        base = ptr[ADDR_W-1:0];
        off  = '0;
        if (wb) begin
            off = wide ? ADDR_W'(CMD_W) : ADDR_W'(CMD_N);
            len = LEN_W'(STAT_B);
        end else begin
            len = wide ? LEN_W'(WIDE_B) : LEN_W'(NARROW_B);
        end
        addr = base + off;
    end
endmodule

// File: rtl/rxd_status_merge.sv
module rxd_status_merge
    import rxd_pkg::*;
(
    input  logic [31:0]      cmd_in,
    input  logic [31:0]      ext_in,
    input  logic [LEN_W-1:0] len,
    input  chk_t             chk,
    input  logic             ext_en,
    output logic [31:0]      cmd_out,
    output logic [31:0]      ext_out
);
    always_comb begin
        cmd_out            = cmd_in;
        cmd_out[CMD_OWN]   = 1'b1;
        cmd_out[CMD_MORE]  = 1'b0;
        cmd_out[CMD_OK]    = 1'b1;
        cmd_out[LEN_W-1:0] = len;

        ext_out = ext_in;
        if (ext_en && chk.ip) begin
            ext_out[EXT_IP] = 1'b1;
            if (chk.ip_err) ext_out[EXT_IPERR] = 1'b1;
            if (chk.tcp) begin
                ext_out[EXT_TCP] = 1'b1;
                if (chk.tcp_err) ext_out[EXT_TCPE] = 1'b1;
            end else if (chk.udp) begin
                ext_out[EXT_UDP] = 1'b1;
                if (chk.udp_err) ext_out[EXT_UDPE] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DLEN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              kick,
    input  logic              mode64,
    input  logic              ext_en,
    input  logic [63:0]       ptr_in,
    output logic              dma_req,
    output logic              dma_write,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [DLEN_W-1:0] dma_len,
    output logic [63:0]       dma_wdata,
    input  logic              dma_done,
    input  logic [63:0]       rd_link,
    input  logic [63:0]       rd_buf,
    input  logic [31:0]       rd_cmd,
    input  logic [31:0]       rd_ext,
    output logic              fill_req,
    output logic [63:0]       fill_ptr,
    output logic [LEN_W-1:0]  fill_cap,
    input  logic              fill_done,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              chk_ip,
    input  logic              chk_ip_err,
    input  logic              chk_tcp,
    input  logic              chk_tcp_err,
    input  logic              chk_udp,
    input  logic              chk_udp_err,
    output logic              busy,
    output logic              irq_ok,
    output logic              irq_desc,
    output logic              irq_idle
);
    typedef struct packed {
        state_e      st;
        logic [63:0] ptr;
        logic        wide;
        desc_t       desc;
        logic        irq_ok;
        logic        irq_desc;
        logic        irq_idle;
    } regs_t;

    regs_t r_q, r_d;
    chk_t  chk;
    logic [31:0] cmd_new, ext_new;

    assign chk = '{ip: chk_ip, ip_err: chk_ip_err, tcp: chk_tcp,
                   tcp_err: chk_tcp_err, udp: chk_udp, udp_err: chk_udp_err};

    rxd_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(DLEN_W)) u_addr (
        .ptr  (r_q.ptr),
        .wide (r_q.wide),
        .wb   (r_q.st == S_WB),
        .addr (dma_addr),
        .len  (dma_len)
    );

    rxd_status_merge u_merge (
        .cmd_in  (r_q.desc.cmd),
        .ext_in  (r_q.desc.ext),
        .len     (pkt_len),
        .chk     (chk),
        .ext_en  (ext_en),
        .cmd_out (cmd_new),
        .ext_out (ext_new)
    );

    always_comb begin
        r_d          = r_q;
        r_d.irq_ok   = 1'b0;
        r_d.irq_desc = 1'b0;
        r_d.irq_idle = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (kick && enable) begin
                    r_d.st   = S_READ;
                    r_d.ptr  = ptr_in;
                    r_d.wide = mode64;
                end
            end
            S_READ: begin
                if (dma_done) begin
                    r_d.desc.cmd  = rd_cmd;
                    r_d.desc.ext  = rd_ext;
                    r_d.desc.link = r_q.wide ? rd_link : {32'd0, rd_link[31:0]};
                    r_d.desc.bufp = r_q.wide ? rd_buf  : {32'd0, rd_buf[31:0]};
                    if (rd_cmd[CMD_OWN]) begin
                        r_d.irq_idle = 1'b1;
                        r_d.st       = S_IDLE;
                    end else begin
                        r_d.st = S_FILL;
                    end
                end
            end
            S_FILL: begin
                if (fill_done) begin
                    r_d.desc.cmd = cmd_new;
                    r_d.desc.ext = ext_new;
                    r_d.st       = S_WB;
                end
            end
            S_WB: begin
                if (dma_done) begin
                    r_d.irq_ok   = 1'b1;
                    r_d.irq_desc = r_q.desc.cmd[CMD_INTR];
                    r_d.st       = enable ? S_ADV : S_IDLE;
                end
            end
            S_ADV: begin
                if (r_q.desc.link == 64'd0) begin
                    r_d.irq_idle = 1'b1;
                    r_d.st       = S_IDLE;
                end else begin
                    r_d.ptr = r_q.desc.link;
                    r_d.st  = S_READ;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dma_req   = (r_q.st == S_READ) || (r_q.st == S_WB);
    assign dma_write = (r_q.st == S_WB);
    assign dma_wdata = {r_q.desc.ext, r_q.desc.cmd};
    assign fill_req  = (r_q.st == S_FILL);
    assign fill_ptr  = r_q.desc.bufp;
    assign fill_cap  = r_q.desc.cmd[LEN_W-1:0];
    assign busy      = (r_q.st != S_IDLE);
    assign irq_ok    = r_q.irq_ok;
    assign irq_desc  = r_q.irq_desc;
    assign irq_idle  = r_q.irq_idle;

    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_done |=> dma_req && $stable(dma_addr) && $stable(dma_write));

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_req && fill_req));

    p_desc_with_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_desc |-> irq_ok);

    p_wb_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_write |-> dma_wdata[CMD_OWN] && !dma_wdata[CMD_MORE]);

    p_wb_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_write |-> dma_len == DLEN_W'(8));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dma_req && !fill_req);

    p_fill_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> $past(dma_req) && !$past(dma_write));
endmodule

// File: tb/rx_desc_ring_test.sv
module rx_desc_ring_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, kick = 1'b0, mode64 = 1'b0, ext_en = 1'b0;
    logic [63:0] ptr_in = '0;
    logic        dma_req, dma_write;
    logic [29:0] dma_addr;
    logic [4:0]  dma_len;
    logic [63:0] dma_wdata;
    logic        dma_done = 1'b0;
    logic [63:0] rd_link = '0, rd_buf = '0;
    logic [31:0] rd_cmd = '0, rd_ext = '0;
    logic        fill_req;
    logic [63:0] fill_ptr;
    logic [15:0] fill_cap;
    logic        fill_done = 1'b0;
    logic [15:0] pkt_len = '0;
    logic        c_ip = 0, c_ipe = 0, c_tcp = 0, c_tcpe = 0, c_udp = 0, c_udpe = 0;
    logic        busy, irq_ok, irq_desc, irq_idle;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rx_desc_ring uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick), .mode64(mode64),
        .ext_en(ext_en), .ptr_in(ptr_in), .dma_req(dma_req), .dma_write(dma_write),
        .dma_addr(dma_addr), .dma_len(dma_len), .dma_wdata(dma_wdata),
        .dma_done(dma_done), .rd_link(rd_link), .rd_buf(rd_buf), .rd_cmd(rd_cmd),
        .rd_ext(rd_ext), .fill_req(fill_req), .fill_ptr(fill_ptr), .fill_cap(fill_cap),
        .fill_done(fill_done), .pkt_len(pkt_len), .chk_ip(c_ip), .chk_ip_err(c_ipe),
        .chk_tcp(c_tcp), .chk_tcp_err(c_tcpe), .chk_udp(c_udp), .chk_udp_err(c_udpe),
        .busy(busy), .irq_ok(irq_ok), .irq_desc(irq_desc), .irq_idle(irq_idle)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_kick(input logic [63:0] p, input logic m);
        @(negedge clk);
        ptr_in = p;
        mode64 = m;
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // Waits for a DMA request and checks kind, address and length.
    task automatic expect_dma(input string tag, input logic wr, input logic [29:0] a,
                              input logic [4:0] l);
        int n = 0;
        while (!dma_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(dma_req, {tag, " req"}, {63'd0, dma_req}, 64'd1);
        check(dma_write == wr, {tag, " write"}, {63'd0, dma_write}, {63'd0, wr});
        check(dma_addr == a, {tag, " addr"}, {34'd0, dma_addr}, {34'd0, a});
        check(dma_len == l, {tag, " len"}, {59'd0, dma_len}, {59'd0, l});
    endtask

    task automatic serve_read(input logic [63:0] lk, input logic [63:0] bf,
                              input logic [31:0] cm, input logic [31:0] ex);
        rd_link = lk; rd_buf = bf; rd_cmd = cm; rd_ext = ex;
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic serve_wb();
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic expect_fill(input string tag, input logic [63:0] p, input logic [15:0] c);
        int n = 0;
        while (!fill_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(fill_req, {tag, " fill_req"}, {63'd0, fill_req}, 64'd1);
        check(fill_ptr == p, {tag, " fill_ptr"}, fill_ptr, p);
        check(fill_cap == c, {tag, " fill_cap"}, {48'd0, fill_cap}, {48'd0, c});
    endtask

    task automatic serve_fill(input logic [15:0] l, input logic [5:0] f);
        pkt_len = l;
        {c_ip, c_ipe, c_tcp, c_tcpe, c_udp, c_udpe} = f;
        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic t_reset();
        check(!busy && !dma_req && !fill_req, "R1 quiet", {61'd0, busy, dma_req, fill_req}, 64'd0);
        check(!irq_ok && !irq_desc && !irq_idle, "R1 irqs",
              {61'd0, irq_ok, irq_desc, irq_idle}, 64'd0);
    endtask

    task automatic t_kick_disabled();
        enable = 1'b0;
        do_kick(64'h100, 1'b0);
        repeat (3) @(negedge clk);
        check(!busy && !dma_req, "R2 kick ignored when disabled", {62'd0, busy, dma_req}, 64'd0);
        enable = 1'b1;
    endtask

    task automatic t_own32();
        do_kick(64'h0000_0000_C000_1000, 1'b0);
        expect_dma("R2 read32", 1'b0, 30'h0000_1000, 5'd16);
        serve_read(64'h0, 64'h0, 32'h8000_0040, 32'h0);
        check(irq_idle, "R3 irq_idle on owned", {63'd0, irq_idle}, 64'd1);
        repeat (2) @(negedge clk);
        check(!busy && !fill_req, "R3 idle no fill", {62'd0, busy, fill_req}, 64'd0);
    endtask

    task automatic t_chain32();
        ext_en = 1'b1;
        do_kick(64'h100, 1'b0);
        expect_dma("R2 chain read", 1'b0, 30'h100, 5'd16);
        serve_read(64'hFFFF_FFFF_0000_0200, 64'hABCD_0000_1234_5678, 32'h6000_05EE, 32'h0);
        expect_fill("R4 narrow", 64'h0000_0000_1234_5678, 16'h05EE);
        serve_fill(16'd60, 6'b101000);
        expect_dma("R7 wb32", 1'b1, 30'h108, 5'd8);
        check(dma_wdata == 64'h000A_0000_A800_003C, "R5 R6 wdata tcp", dma_wdata,
              64'h000A_0000_A800_003C);
        mode64 = 1'b1;
        serve_wb();
        check(irq_ok && irq_desc, "R8 ok and desc", {62'd0, irq_ok, irq_desc}, 64'd3);
        expect_dma("R9 follow link", 1'b0, 30'h200, 5'd16);
        check(1'b1, "R12 length kept after mode change", {59'd0, dma_len}, 64'd16);
        ext_en = 1'b0;
        serve_read(64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_9000, 32'h4000_0064, 32'h0000_0001);
        expect_fill("R4 second", 64'h9000, 16'd100);
        serve_fill(16'd42, 6'b100011);
        expect_dma("R12 wb offset kept", 1'b1, 30'h208, 5'd8);
        check(dma_wdata == 64'h0000_0001_8800_002A, "R6 ext unchanged when off", dma_wdata,
              64'h0000_0001_8800_002A);
        serve_wb();
        check(irq_ok && !irq_desc, "R8 ok without desc", {62'd0, irq_ok, irq_desc}, 64'd2);
        @(negedge clk);
        check(irq_idle, "R9 zero link idle irq", {63'd0, irq_idle}, 64'd1);
        @(negedge clk);
        check(!busy && !dma_req, "R9 stopped", {62'd0, busy, dma_req}, 64'd0);
    endtask

    task automatic t_chain64();
        ext_en = 1'b1;
        do_kick(64'h0000_0000_4000_0040, 1'b1);
        mode64 = 1'b0;
        expect_dma("R2 read64", 1'b0, 30'h40, 5'd24);
        serve_read(64'h0000_0001_0000_0300, 64'h0000_0001_2345_6780, 32'h0000_0200, 32'h0);
        expect_fill("R4 wide", 64'h0000_0001_2345_6780, 16'h0200);
        serve_fill(16'h01FF, 6'b110011);
        expect_dma("R7 wb64", 1'b1, 30'h50, 5'd8);
        check(dma_wdata == 64'h0066_0000_8800_01FF, "R6 udp flags wide", dma_wdata,
              64'h0066_0000_8800_01FF);
        serve_wb();
        check(irq_ok && !irq_desc, "R8 ok wide", {62'd0, irq_ok, irq_desc}, 64'd2);
        expect_dma("R9 wide link", 1'b0, 30'h300, 5'd24);
        serve_read(64'h0, 64'h0, 32'h8000_0000, 32'h0);
        check(irq_idle, "R3 owned on wide", {63'd0, irq_idle}, 64'd1);
        @(negedge clk);
    endtask

    task automatic t_disable();
        ext_en = 1'b1;
        do_kick(64'h400, 1'b0);
        expect_dma("R11 read", 1'b0, 30'h400, 5'd16);
        serve_read(64'h500, 64'h7000, 32'h0000_0010, 32'h0);
        expect_fill("R11 fill", 64'h7000, 16'h0010);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check(fill_req && busy, "R11 fill kept while disabled", {62'd0, fill_req, busy}, 64'd3);
        serve_fill(16'd16, 6'b101011);
        expect_dma("R11 wb still done", 1'b1, 30'h408, 5'd8);
        check(dma_wdata == 64'h000A_0000_8800_0010, "R6 tcp wins over udp", dma_wdata,
              64'h000A_0000_8800_0010);
        serve_wb();
        check(irq_ok, "R11 ok after wb", {63'd0, irq_ok}, 64'd1);
        repeat (4) @(negedge clk);
        check(!busy && !dma_req, "R11 no read after disable", {62'd0, busy, dma_req}, 64'd0);
        enable = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_kick_disabled();
        t_own32();
        t_chain32();
        t_chain64();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule